// File: doc/BRIEF.md
# Load Effective Address Generator

This block forms the memory address and the updated base-register value for a family of register loads. Each request carries a base value, an offset source (a zero-extended immediate, or an index register passed through a barrel shifter that can also consume the carry flag) and a set of mode flags. The mode flags select pre- or post-indexing, add or subtract, optional base writeback, access size, unprivileged access, and an access flavor. The flavors are normal, exclusive, data prefetch, instruction prefetch and floating-point.

The result is registered and appears on the edge after the request. It includes the address to use for the access, the base value to write back together with its enable, the request attributes seen by the memory side, and an alignment fault. The fault applies the alignment rule of the selected flavor and size. It lasts one cycle and cancels the writeback.

Top module: `load_ea_unit`

## Requirements
- R1: All outputs update on the rising edge after a cycle with `inValid` high, and `outValid` goes high for that one cycle. After a cycle with `inValid` low, `outValid`, `wbEn`, `alignFault`, `reqUnpriv`, `reqLinked`, `reqPrefetch`, `reqInstPf` and `reqSize` are all 0. Reset (active-low `rstN`) clears every output to 0.
- R2: With `postIdx` = 1, `effAddr` is the unmodified `baseVal`. With `postIdx` = 0, `effAddr` is the base combined with the offset.
- R3: `addOff` = 1 adds the offset to the base and `addOff` = 0 subtracts it, modulo 2^32. The same result is used both as the pre-indexed address and as `wbValue`.
- R4: With `useReg` = 0, the offset is the 12-bit `immOff` zero-extended to 32 bits.
- R5: With `useReg` = 1, the offset is `idxVal` shifted by `shAmt` (0..31). `shType` 00 is a logical left shift, 01 a logical right shift, 10 an arithmetic right shift and 11 a right rotate. An amount of 0 leaves `idxVal` unchanged for the left, logical-right and arithmetic-right shifts.
- R6: A right rotate with an amount of 0 is a one-bit rotate through carry, giving {`carryIn`, `idxVal`[31:1]}.
- R7: `wbValue` always holds base ± offset. `wbEn` is 1 only when `wbReq` is 1, the flavor is not a prefetch, and no alignment fault is raised.
- R8: `flavorSel` is encoded as 000 normal, 001 exclusive, 010 data prefetch, 011 instruction prefetch and 100 floating-point; 101 to 111 act as normal. `accSize` is encoded as 00 byte, 01 half, 10 word and 11 dual-word. The alignment needed by `effAddr` depends on these fields. A normal single access or any prefetch has no alignment rule. A normal dual-word access needs 4-byte alignment. An exclusive access needs alignment to its own size, which is 8 bytes for a dual-word. A floating-point access needs 4-byte alignment.
- R9: A misaligned access sets `alignFault` together with `outValid` for that one cycle only, and forces `wbEn` to 0.
- R10: `reqUnpriv` follows `userMode`. `reqLinked` is set for the exclusive flavor. `reqPrefetch` is set for both prefetch flavors. `reqInstPf` is set only for the instruction prefetch flavor.
- R11: For both prefetch flavors, `reqSize` is forced to 00 (byte), whatever `accSize` is, and the base is never written back. For every other flavor, `reqSize` equals `accSize`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| baseVal | input | 32 | Base register value |
| immOff | input | 12 | Immediate offset |
| useReg | input | 1 | 1 selects the shifted index register as the offset |
| idxVal | input | 32 | Index register value |
| shAmt | input | 5 | Shift amount |
| shType | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carryIn | input | 1 | Carry flag for the rotate-through-carry case |
| postIdx | input | 1 | 1 selects post-indexed addressing |
| addOff | input | 1 | 1 adds the offset, 0 subtracts it |
| wbReq | input | 1 | Base writeback requested |
| accSize | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 dual |
| userMode | input | 1 | Unprivileged variant |
| flavorSel | input | 3 | Access flavor |
| outValid | output | 1 | Result valid |
| effAddr | output | 32 | Effective address |
| wbValue | output | 32 | Updated base value |
| wbEn | output | 1 | Base writeback enable |
| alignFault | output | 1 | Alignment fault |
| reqUnpriv | output | 1 | Unprivileged request attribute |
| reqLinked | output | 1 | Load-linked request attribute |
| reqPrefetch | output | 1 | Prefetch request attribute |
| reqInstPf | output | 1 | Instruction-side prefetch attribute |
| reqSize | output | 2 | Request size sent to memory |

## Verification
Every result is due exactly one rising edge after the request. Nothing is computed combinationally through to the ports, and no output takes more than one cycle. The bench drives a request on a falling edge and lifts the strobe at the next falling edge. It compares every output at that same falling edge, half a cycle after the capturing edge. At regular points in the sweep it lets one idle cycle pass and checks that the valid-qualified outputs have returned to 0. The sweep covers every flavor code, size, indexing mode, sign, writeback setting, offset source, shift kind, a set of shift amounts that includes 0 and 31, and both carry values.

// File: rtl/load_ea_pkg.sv
package load_ea_pkg;

  localparam logic [2:0] FLV_NORMAL = 3'd0;
  localparam logic [2:0] FLV_EXCL   = 3'd1;
  localparam logic [2:0] FLV_DPF    = 3'd2;
  localparam logic [2:0] FLV_IPF    = 3'd3;
  localparam logic [2:0] FLV_FP     = 3'd4;

  localparam logic [1:0] SH_LSL = 2'd0;
  localparam logic [1:0] SH_LSR = 2'd1;
  localparam logic [1:0] SH_ASR = 2'd2;
  localparam logic [1:0] SH_ROR = 2'd3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DUAL = 2'd3;

  // strobes passed from control to datapath
  typedef struct packed {
    logic       capture;    // load the result registers this cycle
    logic [2:0] alignMask;  // low address bits that must be zero
    logic       wbAllow;    // flavor permits base writeback
  } dpStrobe_t;

endpackage

// File: rtl/load_ea_shifter.sv
module load_ea_shifter #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] idxIn,
  input  logic [SH_W-1:0]   amount,
  input  logic [1:0]        kind,
  input  logic              carryIn,
  output logic [DATA_W-1:0] shifted
);
  import load_ea_pkg::*;

  logic [2*DATA_W-1:0] rotWide;
  logic [DATA_W-1:0]   rotOut;
  logic [DATA_W-1:0]   asrOut;

  always_comb begin
    rotWide = {idxIn, idxIn} >> amount;
    rotOut  = rotWide[DATA_W-1:0];
    asrOut  = $unsigned($signed(idxIn) >>> amount);
  end

  always_comb begin
    unique case (kind)
      SH_LSL:  shifted = idxIn << amount;
      SH_LSR:  shifted = idxIn >> amount;
      SH_ASR:  shifted = asrOut;
      default: shifted = (amount == '0) ? {carryIn, idxIn[DATA_W-1:1]} : rotOut;
    endcase
  end

endmodule

// File: rtl/load_ea_ctrl.sv
module load_ea_ctrl
  import load_ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] accSize,
  input  logic       userMode,
  input  logic [2:0] flavorSel,
  output dpStrobe_t  strobe,
  output logic       outValid,
  output logic       reqUnpriv,
  output logic       reqLinked,
  output logic       reqPrefetch,
  output logic       reqInstPf,
  output logic [1:0] reqSize
);

  logic       isExcl, isPf, isIpf, isFp;
  logic [2:0] maskNext;

  always_comb begin
    isExcl = (flavorSel == FLV_EXCL);
    isIpf  = (flavorSel == FLV_IPF);
    isPf   = (flavorSel == FLV_DPF) || isIpf;
    isFp   = (flavorSel == FLV_FP);
    if (isPf)
      maskNext = 3'b000;
    else if (isFp)
      maskNext = 3'b011;
    else if (isExcl) begin
      unique case (accSize)
        SZ_BYTE: maskNext = 3'b000;
        SZ_HALF: maskNext = 3'b001;
        SZ_WORD: maskNext = 3'b011;
        default: maskNext = 3'b111;
      endcase
    end else
      maskNext = (accSize == SZ_DUAL) ? 3'b011 : 3'b000;
  end

  always_comb begin
    strobe.capture   = inValid;
    strobe.alignMask = maskNext;
    strobe.wbAllow   = ~isPf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      reqUnpriv   <= 1'b0;
      reqLinked   <= 1'b0;
      reqPrefetch <= 1'b0;
      reqInstPf   <= 1'b0;
      reqSize     <= SZ_BYTE;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        reqUnpriv   <= userMode;
        reqLinked   <= isExcl;
        reqPrefetch <= isPf;
        reqInstPf   <= isIpf;
        reqSize     <= isPf ? SZ_BYTE : accSize;
      end else begin
        reqUnpriv   <= 1'b0;
        reqLinked   <= 1'b0;
        reqPrefetch <= 1'b0;
        reqInstPf   <= 1'b0;
        reqSize     <= SZ_BYTE;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !reqLinked && !reqPrefetch && !reqUnpriv));
  assert_inst_is_pf_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqInstPf |-> reqPrefetch);
  assert_pf_byte_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqPrefetch |-> (reqSize == SZ_BYTE));

endmodule

// File: rtl/load_ea_dp.sv
module load_ea_dp
  import load_ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOff,
  input  logic              useReg,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [1:0]        shType,
  input  logic              carryIn,
  input  logic              postIdx,
  input  logic              addOff,
  input  logic              wbReq,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] wbValue,
  output logic              wbEn,
  output logic              alignFault
);

  logic [ADDR_W-1:0] shiftedIdx, offsetVal, combined, eaNext;
  logic              faultNext;

  load_ea_shifter #(.DATA_W(ADDR_W)) shifter_i (
    .idxIn  (idxVal),
    .amount (shAmt),
    .kind   (shType),
    .carryIn(carryIn),
    .shifted(shiftedIdx)
  );

  always_comb begin
    offsetVal = useReg ? shiftedIdx : {{(ADDR_W-IMM_W){1'b0}}, immOff};
    combined  = addOff ? (baseVal + offsetVal) : (baseVal - offsetVal);
    eaNext    = postIdx ? baseVal : combined;
    faultNext = |(eaNext[2:0] & strobe.alignMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr    <= '0;
      wbValue    <= '0;
      wbEn       <= 1'b0;
      alignFault <= 1'b0;
    end else if (strobe.capture) begin
      effAddr    <= eaNext;
      wbValue    <= combined;
      alignFault <= faultNext;
      wbEn       <= wbReq & strobe.wbAllow & ~faultNext;
    end else begin
      wbEn       <= 1'b0;
      alignFault <= 1'b0;
    end
  end

  assert_fault_blocks_wb_R9: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !wbEn);
  assert_post_uses_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && postIdx) |=> (effAddr == $past(baseVal)));
  assert_no_request_no_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !wbReq) |=> !wbEn);

endmodule

// File: rtl/load_ea_unit.sv
module load_ea_unit
  import load_ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOff,
  input  logic              useReg,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [1:0]        shType,
  input  logic              carryIn,
  input  logic              postIdx,
  input  logic              addOff,
  input  logic              wbReq,
  input  logic [1:0]        accSize,
  input  logic              userMode,
  input  logic [2:0]        flavorSel,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] wbValue,
  output logic              wbEn,
  output logic              alignFault,
  output logic              reqUnpriv,
  output logic              reqLinked,
  output logic              reqPrefetch,
  output logic              reqInstPf,
  output logic [1:0]        reqSize
);

  dpStrobe_t strobe;

  load_ea_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .accSize    (accSize),
    .userMode   (userMode),
    .flavorSel  (flavorSel),
    .strobe     (strobe),
    .outValid   (outValid),
    .reqUnpriv  (reqUnpriv),
    .reqLinked  (reqLinked),
    .reqPrefetch(reqPrefetch),
    .reqInstPf  (reqInstPf),
    .reqSize    (reqSize)
  );

  load_ea_dp #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .baseVal   (baseVal),
    .immOff    (immOff),
    .useReg    (useReg),
    .idxVal    (idxVal),
    .shAmt     (shAmt),
    .shType    (shType),
    .carryIn   (carryIn),
    .postIdx   (postIdx),
    .addOff    (addOff),
    .wbReq     (wbReq),
    .effAddr   (effAddr),
    .wbValue   (wbValue),
    .wbEn      (wbEn),
    .alignFault(alignFault)
  );

  assert_pf_never_wb_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqPrefetch |-> !wbEn);
  assert_fault_with_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> outValid);

endmodule

// File: tb/load_ea_unit_tb.sv
`timescale 1ns/1ps
module load_ea_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] baseVal = '0;
  logic [11:0] immOff = '0;
  logic        useReg = 1'b0;
  logic [31:0] idxVal = '0;
  logic [4:0]  shAmt = '0;
  logic [1:0]  shType = '0;
  logic        carryIn = 1'b0;
  logic        postIdx = 1'b0;
  logic        addOff = 1'b0;
  logic        wbReq = 1'b0;
  logic [1:0]  accSize = '0;
  logic        userMode = 1'b0;
  logic [2:0]  flavorSel = '0;
  logic        outValid, wbEn, alignFault, reqUnpriv, reqLinked, reqPrefetch, reqInstPf;
  logic [31:0] effAddr, wbValue;
  logic [1:0]  reqSize;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  load_ea_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseVal(baseVal), .immOff(immOff),
    .useReg(useReg), .idxVal(idxVal), .shAmt(shAmt), .shType(shType), .carryIn(carryIn),
    .postIdx(postIdx), .addOff(addOff), .wbReq(wbReq), .accSize(accSize),
    .userMode(userMode), .flavorSel(flavorSel), .outValid(outValid), .effAddr(effAddr),
    .wbValue(wbValue), .wbEn(wbEn), .alignFault(alignFault), .reqUnpriv(reqUnpriv),
    .reqLinked(reqLinked), .reqPrefetch(reqPrefetch), .reqInstPf(reqInstPf),
    .reqSize(reqSize)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelShift(input logic [31:0] x, input int a,
                                             input int k, input logic c);
    logic [31:0] r;
    case (k)
      0: r = x << a;
      1: r = x >> a;
      2: r = $unsigned($signed(x) >>> a);
      default: r = (a == 0) ? {c, x[31:1]} : ((x >> a) | (x << (32 - a)));
    endcase
    return r;
  endfunction

  task automatic idleCheck();
    @(negedge clk);
    checkVal("R1 idle outValid", {31'b0, outValid}, 0);
    checkVal("R1 idle wbEn", {31'b0, wbEn}, 0);
    checkVal("R1 idle alignFault", {31'b0, alignFault}, 0);
    checkVal("R1 idle attrs", {26'b0, reqUnpriv, reqLinked, reqPrefetch, reqInstPf, reqSize}, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    int amts[4] = '{0, 1, 13, 31};
    int txn = 0;
    repeat (3) @(negedge clk);
    // reset state
    checkVal("R1 reset outValid", {31'b0, outValid}, 0);
    checkVal("R1 reset effAddr", effAddr, 0);
    checkVal("R1 reset wbValue", wbValue, 0);
    checkVal("R1 reset flags", {25'b0, wbEn, alignFault, reqUnpriv, reqLinked,
                                reqPrefetch, reqInstPf, reqSize[0]}, 0);
    rstN = 1'b1;
    idleCheck();

    for (int flv = 0; flv < 8; flv++)
      for (int sz = 0; sz < 4; sz++)
        for (int mode = 0; mode < 8; mode++)
          for (int ur = 0; ur < 2; ur++)
            for (int st = 0; st < 4; st++)
              for (int ai = 0; ai < 4; ai++)
                for (int cy = 0; cy < 2; cy++) begin
                  logic [31:0] off, sum, ea;
                  int need;
                  logic isPf, isIpf, isExcl, expFault, expWb;
                  string offTag;
                  seed = seed * 32'd1664525 + 32'd1013904223;
                  @(negedge clk);
                  inValid   = 1'b1;
                  baseVal   = seed;
                  idxVal    = {seed[15:0], seed[31:16]} ^ 32'h9e37_79b9;
                  immOff    = seed[23:12];
                  flavorSel = flv[2:0];
                  accSize   = sz[1:0];
                  postIdx   = mode[0];
                  addOff    = mode[1];
                  wbReq     = mode[2];
                  useReg    = ur[0];
                  shType    = st[1:0];
                  shAmt     = amts[ai][4:0];
                  carryIn   = cy[0];
                  userMode  = seed[7];
                  // expected values
                  off = ur ? modelShift(idxVal, amts[ai], st, cy[0]) : {20'b0, immOff};
                  offTag = !ur ? "R4" : ((st == 3 && amts[ai] == 0) ? "R6" : "R5");
                  sum = mode[1] ? baseVal + off : baseVal - off;
                  ea  = mode[0] ? baseVal : sum;
                  isExcl = (flv == 1);
                  isIpf  = (flv == 3);
                  isPf   = (flv == 2) || isIpf;
                  if (isPf) need = 1;
                  else if (flv == 4) need = 4;
                  else if (isExcl) need = 1 << sz;
                  else need = (sz == 3) ? 4 : 1;
                  expFault = (ea % need) != 0;
                  expWb = mode[2] && !isPf && !expFault;
                  @(negedge clk);
                  inValid = 1'b0;
                  checkVal("R1 outValid", {31'b0, outValid}, 1);
                  checkVal("R2 effAddr", effAddr, ea);
                  checkVal($sformatf("R3 %s wbValue", offTag), wbValue, sum);
                  checkVal(expFault ? "R9 wbEn" : "R7 wbEn", {31'b0, wbEn}, {31'b0, expWb});
                  checkVal("R8 alignFault", {31'b0, alignFault}, {31'b0, expFault});
                  checkVal("R10 attrs", {28'b0, reqUnpriv, reqLinked, reqPrefetch, reqInstPf},
                           {28'b0, userMode, isExcl, isPf, isIpf});
                  checkVal("R11 reqSize", {30'b0, reqSize}, isPf ? 32'd0 : sz);
                  txn++;
                  if (txn % 61 == 0) idleCheck();
                end

    idleCheck();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule